// File: doc/BRIEF.md
# Byte-Latched Up/Down Tick Counter

This block holds a 16-bit counter that a processor reaches through an 8-bit register port. The count shows at two byte addresses. The processor never touches the upper half of the live counter directly. A single 8-bit staging byte sits between the bus and that upper half: reading the lower byte captures the upper half into the staging byte, and writing the lower byte commits the staging byte and the bus byte together. Because of this, a whole 16-bit value moves in one step, even though the bus is only one byte wide.

The counter moves only on a one-cycle tick enable, and only while the clock-select field is non-zero. On an accepted tick the controls choose between clearing, counting up, counting down and holding. Two level outputs report that the count is at its maximum or at zero. A one-cycle pulse reports an upward wrap.

A two-state machine tracks the clock-select field. HALT is entered when the field is 000 and RUN is entered when it is non-zero; the transition HALT->RUN or RUN->HALT occurs on the next clock edge. Ticks are accepted only in RUN. A change of the select field therefore takes effect one cycle after it is applied.

Top module: `updn_bytecnt`

## Requirements
- R1: After reset the counter and the staging byte are 0x0000 and 0x00, `at_bottom` is 1, `at_top` is 0 and `wrap_pulse` is 0.
- R2: A read with `bus_addr`=0 returns the counter bits 7:0 in the same cycle and copies counter bits 15:8 into the staging byte at the clock edge. A later read with `bus_addr`=1 returns that copy, even if the counter has moved since.
- R3: A write with `bus_addr`=1 changes only the staging byte. The counter keeps its value until the next write with `bus_addr`=0.
- R4: A write with `bus_addr`=0 loads the counter with {staging byte, bus byte} at that clock edge.
- R5: On an accepted tick, `cnt_clr`=1 makes the counter 0, whatever `cnt_en` is. Otherwise, with `cnt_en`=1 the counter decrements by 1 when `cnt_down`=1 and increments by 1 when `cnt_down`=0. With `cnt_en`=0 it holds.
- R6: A tick is accepted only in state RUN. The machine is in RUN in a cycle when `clk_sel` was non-zero in the previous cycle. While `clk_sel`=000 the counter ignores ticks, but it can still be read and written.
- R7: A write with `bus_addr`=0 takes priority over a clear or count in the same cycle.
- R8: `at_top` is 1 exactly when the counter is 0xFFFF, and `at_bottom` is 1 exactly when it is 0x0000.
- R9: `wrap_pulse` is 1 for the single cycle after an accepted increment takes the counter from 0xFFFF to 0x0000. A downward wrap, a clear or a load never raises it.
- R10: The counter wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 selects the lower byte, 1 selects the staging byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| tick | input | 1 | One-cycle timer tick enable |
| clk_sel | input | 3 | Clock select; 000 stops the counter |
| cnt_en | input | 1 | Count enable |
| cnt_down | input | 1 | 1 counts down, 0 counts up |
| cnt_clr | input | 1 | Clear on tick |
| at_top | output | 1 | Counter equals its maximum |
| at_bottom | output | 1 | Counter equals zero |
| wrap_pulse | output | 1 | Upward wrap indication, one cycle |

## Verification
The two functions that can fall in the same cycle are a lower-byte write from the bus and an accepted tick that clears or counts. This is provoked directly with a write issued on the same edge as an enabled tick. It is also provoked many times over by random stimulus that drives strobes and ticks independently. The result is judged by reading the counter back: it must equal the written word, with no clear or count applied. A second overlap is a lower-byte read on the same edge as a count. Here the staging byte must hold the upper half from before the edge.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;
    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/bcnt_regport.sv
module bcnt_regport #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              load_en,
    output logic [CNT_W-1:0]  load_val
);
    logic [BYTE_W-1:0] stage_q;
    logic              lo_rd, hi_wr;

    assign lo_rd = bus_rd && !bus_addr;
    assign hi_wr = bus_wr && bus_addr;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (hi_wr)
            stage_q <= bus_wdata;
        else if (lo_rd)
            stage_q <= cnt_q[CNT_W-1:BYTE_W];
    end

    always_comb begin
        bus_rdata = bus_addr ? stage_q : cnt_q[BYTE_W-1:0];
        load_en   = bus_wr && !bus_addr;
        load_val  = {stage_q, bus_wdata};
    end

    // R2: a low-byte read captures the upper counter half
    p_stage_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && !hi_wr) |=> (stage_q == $past(cnt_q[CNT_W-1:BYTE_W])));

    // R3: staging byte only moves on a high write or a low read
    p_stage_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_rd && !hi_wr) |=> $stable(stage_q));
endmodule

// File: rtl/bcnt_core.sv
module bcnt_core
    import bcnt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             cnt_en,
    input  logic             cnt_down,
    input  logic             cnt_clr,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap_pulse
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    run_state_t state_q, state_d;
    logic       accept;
    logic       up_wrap;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (clk_sel != '0) state_d = ST_RUN;
            ST_RUN:  if (clk_sel == '0) state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        accept = 1'b0;
        unique case (state_q)
            ST_HALT: accept = 1'b0;
            ST_RUN:  accept = tick;
        endcase
        up_wrap = accept && !load_en && !cnt_clr && cnt_en && !cnt_down
                  && (cnt_q == MAXV);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= up_wrap;
            if (load_en)
                cnt_q <= load_val;
            else if (accept) begin
                if (cnt_clr)
                    cnt_q <= '0;
                else if (cnt_en && cnt_down)
                    cnt_q <= cnt_q - 1'b1;
                else if (cnt_en)
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6: nothing but a load moves the counter while halted
    p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !load_en) |=> $stable(cnt_q));

    // R7: a bus load wins over any tick action
    p_load_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cnt_q == $past(load_val)));

    // R5: clear beats count on an accepted tick
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cnt_clr && !load_en) |=> (cnt_q == '0));

    // R9: the wrap pulse coincides with a zero count that followed the maximum
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_pulse) |-> (cnt_q == '0 && $past(cnt_q) == MAXV));
endmodule

// File: rtl/updn_bytecnt.sv
module updn_bytecnt #(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              cnt_en,
    input  logic              cnt_down,
    input  logic              cnt_clr,
    output logic              at_top,
    output logic              at_bottom,
    output logic              wrap_pulse
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             load_en;

    bcnt_regport #(.BYTE_W(BYTE_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cnt_q     (cnt_q),
        .bus_rdata (bus_rdata),
        .load_en   (load_en),
        .load_val  (load_val)
    );

    bcnt_core #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .clk_sel    (clk_sel),
        .cnt_en     (cnt_en),
        .cnt_down   (cnt_down),
        .cnt_clr    (cnt_clr),
        .load_en    (load_en),
        .load_val   (load_val),
        .cnt_q      (cnt_q),
        .wrap_pulse (wrap_pulse)
    );

    assign at_top    = (cnt_q == {CNT_W{1'b1}});
    assign at_bottom = (cnt_q == '0);

    // R8: the two flags can never be high together
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_top && at_bottom));
endmodule

// File: tb/sim_updn_bytecnt.sv
`timescale 1ns/1ps
module sim_updn_bytecnt;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_addr, bus_rd, bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       tick, cnt_en, cnt_down, cnt_clr;
    logic [2:0] clk_sel;
    logic       at_top, at_bottom, wrap_pulse;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_cnt;
    logic [7:0]  m_stg;
    logic        m_run, m_wrap;

    always #2.5 clk = ~clk;

    updn_bytecnt u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .clk_sel(clk_sel), .cnt_en(cnt_en), .cnt_down(cnt_down),
        .cnt_clr(cnt_clr), .at_top(at_top), .at_bottom(at_bottom),
        .wrap_pulse(wrap_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] next_cnt(input logic [15:0] c, input logic acc,
                                              input logic clr, input logic en,
                                              input logic dn);
        if (!acc || (!clr && !en)) return c;
        if (clr) return 16'h0000;
        return dn ? c - 16'd1 : c + 16'd1;
    endfunction

    // one bus/tick cycle; inputs applied after a falling edge
    task automatic cyc(input string req, input logic a, input logic rd, input logic wr,
                       input logic [7:0] wd, input logic tk, input logic [2:0] sel,
                       input logic en, input logic dn, input logic clr);
        logic acc, wlo;
        logic [7:0] exp_rd;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        tick = tk; clk_sel = sel; cnt_en = en; cnt_down = dn; cnt_clr = clr;
        #1;
        if (rd) begin
            exp_rd = a ? m_stg : m_cnt[7:0];
            check(bus_rdata == exp_rd, req, bus_rdata, exp_rd);
        end
        acc = m_run && tk;
        wlo = wr && !a;
        m_wrap = acc && !wlo && !clr && en && !dn && (m_cnt == 16'hFFFF);
        if (wlo)          m_cnt = {m_stg, wd};
        else              m_cnt = next_cnt(m_cnt, acc, clr, en, dn);
        if (wr && a)      m_stg = wd;
        else if (rd && !a) m_stg = m_cnt_hi_pre;
        m_run = (sel != 3'b000);
        @(posedge clk);
        @(negedge clk);
        check(at_top == (m_cnt == 16'hFFFF), "R8 top", at_top, m_cnt == 16'hFFFF);
        check(at_bottom == (m_cnt == 16'h0000), "R8 bottom", at_bottom, m_cnt == 16'h0000);
        check(wrap_pulse == m_wrap, "R9 wrap", wrap_pulse, m_wrap);
    endtask

    // upper half captured before the model counter update
    logic [7:0] m_cnt_hi_pre;

    task automatic step(input string req, input logic a, input logic rd, input logic wr,
                        input logic [7:0] wd, input logic tk, input logic [2:0] sel,
                        input logic en, input logic dn, input logic clr);
        m_cnt_hi_pre = m_cnt[15:8];
        cyc(req, a, rd, wr, wd, tk, sel, en, dn, clr);
    endtask

    task automatic idle(input string req, input logic [2:0] sel);
        step(req, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, sel, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic load16(input string req, input logic [15:0] v, input logic [2:0] sel);
        step(req, 1'b1, 1'b0, 1'b1, v[15:8], 1'b0, sel, 1'b0, 1'b0, 1'b0);
        step(req, 1'b0, 1'b0, 1'b1, v[7:0], 1'b0, sel, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic read16(input string req, input logic [2:0] sel);
        step(req, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, sel, 1'b0, 1'b0, 1'b0);
        step(req, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, sel, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic tk(input string req, input logic [2:0] sel, input logic en,
                      input logic dn, input logic clr);
        step(req, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, sel, en, dn, clr);
    endtask

    initial begin
        #150000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
        tick = 0; clk_sel = 0; cnt_en = 0; cnt_down = 0; cnt_clr = 0;
        m_cnt = 0; m_stg = 0; m_run = 0; m_wrap = 0; m_cnt_hi_pre = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(at_bottom == 1'b1, "R1 bottom", at_bottom, 1);
        check(at_top == 1'b0, "R1 top", at_top, 0);
        check(wrap_pulse == 1'b0, "R1 wrap", wrap_pulse, 0);
        read16("R1 reset read", 3'b000);

        // R3 high write leaves counter alone
        step("R3", 1'b1, 1'b0, 1'b1, 8'h12, 1'b0, 3'b000, 0, 0, 0);
        read16("R3 counter unchanged", 3'b000);
        // R4 atomic load
        load16("R4", 16'hABCD, 3'b000);
        read16("R4 readback", 3'b000);

        // R6 halted: ticks ignored
        tk("R6", 3'b000, 1, 0, 0);
        tk("R6", 3'b000, 1, 0, 1);
        read16("R6 held", 3'b000);
        // select takes effect one cycle later: this tick is ignored
        tk("R6 late", 3'b001, 1, 0, 0);
        read16("R6 late", 3'b001);

        // R10 R9 upward wrap
        load16("R10", 16'hFFFE, 3'b001);
        tk("R10 inc", 3'b001, 1, 0, 0);
        tk("R9 R10 wrap", 3'b001, 1, 0, 0);
        read16("R10 zero", 3'b001);
        tk("R10 down wrap", 3'b001, 1, 1, 0);
        read16("R10 ffff", 3'b001);
        // R5 clear wins over count, hold with en=0
        tk("R5 clr", 3'b010, 1, 0, 1);
        load16("R5", 16'h0100, 3'b010);
        tk("R5 hold", 3'b010, 0, 0, 0);
        tk("R5 dec", 3'b010, 1, 1, 0);
        read16("R5 value", 3'b010);
        // R7 load vs tick in same cycle
        step("R7", 1'b1, 1'b0, 1'b1, 8'h5A, 1'b0, 3'b010, 0, 0, 0);
        step("R7", 1'b0, 1'b0, 1'b1, 8'hA5, 1'b1, 3'b010, 1, 0, 1);
        read16("R7 readback", 3'b010);
        // R2 coherent pair: count between the two reads
        load16("R2", 16'h12FF, 3'b010);
        step("R2 low", 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 3'b010, 1, 0, 0);
        tk("R2", 3'b010, 1, 0, 0);
        step("R2 high", 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 3'b010, 0, 0, 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            logic [2:0] s = (r[2:0] == 3'b000 && r[3]) ? 3'b000 : (r[2:0] | 3'b001);
            step("R2 R4 R5 R7 random", r[4], r[5], r[6] & r[7], r[15:8], r[16] | r[17],
                 (r[30:28] == 3'b000) ? 3'b000 : s, r[18] | r[19], r[20], r[21] & r[22] & r[23]);
        end
        read16("R10 final", 3'b001);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule